// File: doc/BRIEF.md
# Two-level interrupt register block

This block gathers the interrupt conditions of one bus-attached peripheral and presents them to software through a small word-addressed register file. It also drives a single interrupt line toward the system. Each source inside the peripheral's core logic sets a sticky bit in a core-level status register. A core-level mask selects which of those bits count, and the masked bits are OR-reduced into one summary. That summary joins a few live device-level conditions and a sticky internal error flag in the device-level status word. A device-level mask turns that word into a pending word. A priority encoder reports the lowest pending index, and a single global enable bit gates the line.

Software clears a sticky bit by writing a 1 to it. Such a write flips the bit, so the same write can also raise a test interrupt on a clear bit. The register bus is a plain single-cycle interface: a write commits on the clock edge and read data follows the address combinationally. Writing one particular key value to the reset register clears every register and sends a one-cycle reset pulse to the rest of the peripheral.

Top module: `irq_regblock`

## Requirements
- R1: After rst_ni is released, every register reads zero and irq_o and dev_rst_o are low, provided the live inputs are low.
- R2: Byte addresses decode as follows: 0 device status, 4 device pending, 8 device enable, 24 priority ID, 28 global enable, 32 core status, 40 core enable, 64 reset. Device enable and core enable are plain read/write registers. Every other address, including the reset register on a read, returns zero, and a write there changes nothing.
- R3: Core status bit i is set by a high core_evt_i[i] at a clock edge and holds until software clears it. A bus write to address 32 inverts every bit written as 1 and leaves every bit written as 0 unchanged.
- R4: When a hardware set and a toggle write hit the same sticky bit in the same cycle, the bit ends at 1. This applies to the core status bits and to the error bit.
- R5: Device status bit 0 is the sticky error flag, set by err_i and flipped by a write of 1 to data bit 0 at address 0. Bit 1 follows dev_live_i[0], bit 2 is the OR of core status AND core enable, and bit k+2 follows dev_live_i[k] for k of 1 or more. Writes to the live bits have no effect. Status is recorded regardless of any enable.
- R6: The pending word at address 4 equals device status AND device enable, and it ignores writes.
- R7: The ID register reads the index of the lowest set pending bit, where bit 0 has the highest priority. It reads 128 when no bit is pending.
- R8: The global enable is data bit 31 at address 28, and it reads back only in bit 31. irq_o is high exactly when that bit is set and the pending word is nonzero.
- R9: A write of 0x0000000A to address 64 clears all registers at that edge, and dev_rst_o is high for the following cycle. Any other value written there has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 7 | Byte address of the register access |
| wr_i | input | 1 | Write strobe, one cycle per write |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for addr_i (combinational) |
| err_i | input | 1 | Internal error event, sets device status bit 0 |
| dev_live_i | input | N_LIVE (3) | Live device-level conditions |
| core_evt_i | input | N_CORE (8) | Core-level interrupt events |
| irq_o | output | 1 | Interrupt line |
| dev_rst_o | output | 1 | One-cycle soft reset pulse to the device |

## Verification
The hardest case to reach is a hardware event that lands on a sticky bit in the same cycle as a toggle write to that bit while the bit is already set. This happens rarely under random traffic, so directed steps first set the bit by event and then issue the write and the event together. A second rare case is the reset key arriving while events and enables are active. Random data seldom hits 0x0000000A, so the random generator substitutes the key in about one reset-register write in eight. A bench model computes expected values in parallel with the design and checks reads, the interrupt line and the reset pulse on every cycle.

// File: rtl/irq_regblock_pkg.sv
package irq_regblock_pkg;
  localparam int unsigned OFS_DSTAT = 0;
  localparam int unsigned OFS_DPEND = 4;
  localparam int unsigned OFS_DEN   = 8;
  localparam int unsigned OFS_ID    = 24;
  localparam int unsigned OFS_GIE   = 28;
  localparam int unsigned OFS_CST   = 32;
  localparam int unsigned OFS_CEN   = 40;
  localparam int unsigned OFS_RST   = 64;
  localparam logic [31:0] RST_KEY   = 32'h0000_000A;
  localparam int unsigned ID_W      = 8;
  localparam logic [ID_W-1:0] ID_NONE = 8'd128;
endpackage

// File: rtl/irq_latch_bank.sv
module irq_latch_bank #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic [W-1:0] set_i,
  input  logic [W-1:0] tog_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] q;

  // hardware set applied after toggle so it wins
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     q <= '0;
    else if (clr_i)  q <= '0;
    else             q <= (q ^ tog_i) | set_i;
  end

  assign q_o = q;

  p_hw_set_wins_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && set_i != '0) |=> ((q_o & $past(set_i)) == $past(set_i)));

  p_toggle_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && set_i == '0) |=> (q_o == ($past(q_o) ^ $past(tog_i))));

  p_clear_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (q_o == '0));
endmodule

// File: rtl/irq_prio_enc.sv
module irq_prio_enc
  import irq_regblock_pkg::*;
#(
  parameter int unsigned W = 8
) (
  input  logic [W-1:0]    req_i,
  output logic [ID_W-1:0] id_o
);
  always_comb begin
    id_o = ID_NONE;
    for (int i = int'(W) - 1; i >= 0; i--) begin
      if (req_i[i]) id_o = ID_W'(i);
    end
  end
endmodule

// File: rtl/irq_regblock.sv
module irq_regblock
  import irq_regblock_pkg::*;
#(
  parameter int unsigned AW     = 7,
  parameter int unsigned N_CORE = 8,
  parameter int unsigned N_LIVE = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [AW-1:0]     addr_i,
  input  logic              wr_i,
  input  logic [31:0]       wdata_i,
  output logic [31:0]       rdata_o,
  input  logic              err_i,
  input  logic [N_LIVE-1:0] dev_live_i,
  input  logic [N_CORE-1:0] core_evt_i,
  output logic              irq_o,
  output logic              dev_rst_o
);
  localparam int unsigned DEV_W = N_LIVE + 2;
  localparam logic [AW-1:0] A_DSTAT = AW'(OFS_DSTAT);
  localparam logic [AW-1:0] A_DPEND = AW'(OFS_DPEND);
  localparam logic [AW-1:0] A_DEN   = AW'(OFS_DEN);
  localparam logic [AW-1:0] A_ID    = AW'(OFS_ID);
  localparam logic [AW-1:0] A_GIE   = AW'(OFS_GIE);
  localparam logic [AW-1:0] A_CST   = AW'(OFS_CST);
  localparam logic [AW-1:0] A_CEN   = AW'(OFS_CEN);
  localparam logic [AW-1:0] A_RST   = AW'(OFS_RST);

  logic              soft_rst, rst_pulse_q;
  logic [N_CORE-1:0] cst_q, cen_q, cst_tog;
  logic [0:0]        err_q, err_tog, err_set;
  logic [DEV_W-1:0]  den_q, dstat, pend;
  logic              gie_q;
  logic [ID_W-1:0]   id;

  assign soft_rst = wr_i && (addr_i == A_RST) && (wdata_i == RST_KEY);
  assign cst_tog  = (wr_i && addr_i == A_CST)   ? wdata_i[N_CORE-1:0] : '0;
  assign err_tog  = (wr_i && addr_i == A_DSTAT) ? wdata_i[0:0] : 1'b0;
  assign err_set  = err_i;

  irq_latch_bank #(.W(N_CORE)) u_core_stat (
    .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(soft_rst),
    .set_i(core_evt_i), .tog_i(cst_tog), .q_o(cst_q)
  );

  irq_latch_bank #(.W(1)) u_err_stat (
    .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(soft_rst),
    .set_i(err_set), .tog_i(err_tog), .q_o(err_q)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cen_q       <= '0;
      den_q       <= '0;
      gie_q       <= 1'b0;
      rst_pulse_q <= 1'b0;
    end else begin
      rst_pulse_q <= soft_rst;
      if (soft_rst) begin
        cen_q <= '0;
        den_q <= '0;
        gie_q <= 1'b0;
      end else if (wr_i) begin
        if (addr_i == A_CEN) cen_q <= wdata_i[N_CORE-1:0];
        if (addr_i == A_DEN) den_q <= wdata_i[DEV_W-1:0];
        if (addr_i == A_GIE) gie_q <= wdata_i[31];
      end
    end
  end

  // device status assembly: 0 error, 1 live[0], 2 core summary, 3.. live[1..]
  assign dstat[0] = err_q[0];
  assign dstat[1] = dev_live_i[0];
  assign dstat[2] = |(cst_q & cen_q);
  for (genvar k = 1; k < N_LIVE; k++) begin : g_live
    assign dstat[k+2] = dev_live_i[k];
  end

  assign pend = dstat & den_q;

  irq_prio_enc #(.W(DEV_W)) u_prio (
    .req_i(pend), .id_o(id)
  );

  always_comb begin
    case (addr_i)
      A_DSTAT: rdata_o = 32'(dstat);
      A_DPEND: rdata_o = 32'(pend);
      A_DEN:   rdata_o = 32'(den_q);
      A_ID:    rdata_o = 32'(id);
      A_GIE:   rdata_o = {gie_q, 31'b0};
      A_CST:   rdata_o = 32'(cst_q);
      A_CEN:   rdata_o = 32'(cen_q);
      default: rdata_o = 32'b0;
    endcase
  end

  assign irq_o     = gie_q && (pend != '0);
  assign dev_rst_o = rst_pulse_q;

  p_id_hits_pending_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend != '0) |-> ((id < ID_W'(DEV_W)) && ((pend & (DEV_W'(1) << id)) != '0)
                      && ((pend & ((DEV_W'(1) << id) - DEV_W'(1))) == '0)));

  p_id_none_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend == '0) |-> (id == ID_NONE));

  p_irq_drops_with_gie_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(gie_q) |-> !irq_o);

  p_reset_pulse_clears_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dev_rst_o |-> (cen_q == '0 && den_q == '0 && !gie_q && cst_q == '0));

  p_pending_masked_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (den_q == '0) |-> !irq_o);
endmodule

// File: tb/irq_regblock_test.sv
`timescale 1ns/1ps
module irq_regblock_test;
  localparam int N_CORE = 8;
  localparam int N_LIVE = 3;
  localparam int DEV_W  = N_LIVE + 2;

  logic              clk = 1'b0;
  logic              rst_ni = 1'b0;
  logic [6:0]        addr = '0;
  logic              wr = 1'b0;
  logic [31:0]       wdata = '0;
  logic [31:0]       rdata;
  logic              err = 1'b0;
  logic [N_LIVE-1:0] live = '0;
  logic [N_CORE-1:0] evt = '0;
  logic              irq, dev_rst;

  always #2 clk = ~clk;

  irq_regblock uut (
    .clk_i(clk), .rst_ni(rst_ni), .addr_i(addr), .wr_i(wr), .wdata_i(wdata),
    .rdata_o(rdata), .err_i(err), .dev_live_i(live), .core_evt_i(evt),
    .irq_o(irq), .dev_rst_o(dev_rst)
  );

  logic [N_CORE-1:0] m_cst, m_cen;
  logic              m_err, m_gie, m_rst;
  logic [DEV_W-1:0]  m_den;
  int n_chk = 0, n_fail = 0;

  function automatic logic [DEV_W-1:0] f_dstat(input logic [N_LIVE-1:0] lv);
    logic [DEV_W-1:0] s;
    s = '0;
    s[0] = m_err;
    s[1] = lv[0];
    s[2] = |(m_cst & m_cen);
    for (int k = 1; k < N_LIVE; k++) s[k+2] = lv[k];
    return s;
  endfunction

  function automatic logic [31:0] f_id(input logic [DEV_W-1:0] p);
    for (int i = 0; i < DEV_W; i++) if (p[i]) return 32'(i);
    return 32'd128;
  endfunction

  function automatic logic [31:0] f_rd(input logic [6:0] a, input logic [N_LIVE-1:0] lv);
    logic [DEV_W-1:0] p;
    p = f_dstat(lv) & m_den;
    case (a)
      7'd0:  return 32'(f_dstat(lv));
      7'd4:  return 32'(p);
      7'd8:  return 32'(m_den);
      7'd24: return f_id(p);
      7'd28: return {m_gie, 31'b0};
      7'd32: return 32'(m_cst);
      7'd40: return 32'(m_cen);
      default: return 32'b0;
    endcase
  endfunction

  function automatic string f_tag(input logic [6:0] a);
    case (a)
      7'd0:  return "R5";
      7'd4:  return "R6";
      7'd24: return "R7";
      7'd28: return "R8";
      7'd32: return "R3";
      default: return "R2";
    endcase
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic step(input logic [6:0] a, input logic w, input logic [31:0] d,
                      input logic e, input logic [N_LIVE-1:0] lv,
                      input logic [N_CORE-1:0] ev, input string tag);
    string t;
    @(negedge clk);
    addr = a; wr = w; wdata = d; err = e; live = lv; evt = ev;
    #1;
    t = (tag == "") ? f_tag(a) : tag;
    chk(t, rdata, f_rd(a, lv));
    chk("R8", 32'(irq), 32'(m_gie && ((f_dstat(lv) & m_den) != '0)));
    chk("R9", 32'(dev_rst), 32'(m_rst));
    if (w && a == 7'd64 && d == 32'hA) begin
      m_cst = '0; m_cen = '0; m_err = 1'b0; m_den = '0; m_gie = 1'b0; m_rst = 1'b1;
    end else begin
      m_rst = 1'b0;
      if (w && a == 7'd32) m_cst = m_cst ^ d[N_CORE-1:0];
      m_cst = m_cst | ev;
      if (w && a == 7'd0) m_err = m_err ^ d[0];
      m_err = m_err | e;
      if (w && a == 7'd40) m_cen = d[N_CORE-1:0];
      if (w && a == 7'd8)  m_den = d[DEV_W-1:0];
      if (w && a == 7'd28) m_gie = d[31];
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [6:0] addrs [17] = '{7'd0, 7'd4, 7'd8, 7'd24, 7'd28, 7'd32, 7'd40, 7'd64,
                               7'd12, 7'd16, 7'd20, 7'd36, 7'd44, 7'd48, 7'd60, 7'd68, 7'd2};
    m_cst = '0; m_cen = '0; m_err = 1'b0; m_den = '0; m_gie = 1'b0; m_rst = 1'b0;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;

    // R1: reset values
    for (int i = 0; i < 17; i++) step(addrs[i], 1'b0, '0, 1'b0, '0, '0, "R1");

    // R2: reserved writes ignored, read zero
    step(7'd12, 1'b1, 32'hFFFF_FFFF, 1'b0, '0, '0, "R2");
    step(7'd8, 1'b0, '0, 1'b0, '0, '0, "R2");
    step(7'd12, 1'b0, '0, 1'b0, '0, '0, "R2");

    // R4: set-and-toggle collision on already-set bits
    step(7'd32, 1'b0, '0, 1'b1, '0, 8'h01, "R4");
    step(7'd32, 1'b1, 32'h1, 1'b0, '0, 8'h01, "R4");
    step(7'd0, 1'b1, 32'h1, 1'b1, '0, '0, "R4");
    step(7'd32, 1'b0, '0, 1'b0, '0, '0, "R4");
    step(7'd0, 1'b0, '0, 1'b0, '0, '0, "R4");

    // R3: toggle clears, zero write keeps
    step(7'd32, 1'b1, 32'h0, 1'b0, '0, '0, "R3");
    step(7'd32, 1'b1, 32'h1, 1'b0, '0, '0, "R3");
    step(7'd32, 1'b0, '0, 1'b0, '0, '0, "R3");

    // R7: priority order and no-pending code
    step(7'd8, 1'b1, 32'h1F, 1'b0, 3'b011, '0, "R7");
    step(7'd24, 1'b0, '0, 1'b0, 3'b011, '0, "R7");
    step(7'd0, 1'b1, 32'h1, 1'b0, 3'b110, '0, "R7");
    step(7'd24, 1'b0, '0, 1'b0, 3'b110, '0, "R7");
    step(7'd24, 1'b0, '0, 1'b0, 3'b000, '0, "R7");

    // R5: live bits not writable
    step(7'd0, 1'b1, 32'h1E, 1'b0, '0, '0, "R5");
    step(7'd0, 1'b0, '0, 1'b0, '0, '0, "R5");

    // R8 + R9: non-key write ignored, key clears
    step(7'd28, 1'b1, 32'h8000_0000, 1'b0, 3'b001, '0, "R8");
    step(7'd64, 1'b1, 32'h5, 1'b0, 3'b001, '0, "R9");
    step(7'd28, 1'b0, '0, 1'b0, 3'b001, '0, "R9");
    step(7'd64, 1'b1, 32'hA, 1'b1, 3'b001, 8'hFF, "R9");
    step(7'd8, 1'b0, '0, 1'b0, 3'b001, '0, "R9");
    step(7'd32, 1'b0, '0, 1'b0, 3'b001, '0, "R9");

    // random traffic
    for (int n = 0; n < 4000; n++) begin
      logic [6:0]  a;
      logic        w;
      logic [31:0] d;
      logic [N_CORE-1:0] ev;
      a  = addrs[$urandom_range(16)];
      w  = ($urandom_range(1) == 1);
      d  = $urandom();
      if (a == 7'd64 && $urandom_range(7) == 0) d = 32'hA;
      ev = 8'($urandom()) & 8'($urandom()) & 8'($urandom());
      step(a, w, d, ($urandom_range(15) == 0), 3'($urandom()), ev, "");
    end

    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule